// File: doc/BRIEF.md
# Ping-Pong Sample Block Buffer

This block sits between a serial-link frame reader and a slow non-volatile memory writer. Each time the reader finishes a frame it presents one 12-byte sample record: a status word followed by one value for each of two channels. The block gathers these records into blocks of 16 in one of two RAM banks. When a bank is full it is handed to the drain side, and the other bank takes over the filling, so capture goes on while the full bank is read out.

The drain side repacks each 192-byte block into 24 output words of 8 bytes. It sends them over a valid/ready handshake, and the first word of each block carries a marker. If a bank fills while the other one is still being drained, records are dropped until a bank is free again, and a sticky flag records that data was lost.

Top module: `sample_pingpong_buf`

## Requirements
- R1: A record presented with `rec_valid` high is accepted whenever the bank being filled is not complete. Sixteen accepted records complete a block.
- R2: A completed block leaves as exactly 24 words, in the order the bytes arrived. Byte k of a record is `rec_data[8k+7:8k]`. Byte n of the block sits in word n/8, lane n%8, where lane i is `wr_data[8i+7:8i]`.
- R3: `wr_first` is high on word 0 of each block and low on every other word.
- R4: `wr_valid` stays low until a block is complete. It goes high in the cycle after the 16th record of a block is accepted.
- R5: When the other bank is empty, filling switches to it at the same clock edge that completes a block. A record presented in the very next cycle is accepted.
- R6: A record that arrives while the filling bank is complete and no swap has yet taken place is dropped, and its bytes never appear on `wr_data`.
- R7: `overflow` goes high in the cycle after the first dropped record and stays high until reset.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_data` and `wr_first` hold their values.
- R9: After reset, `wr_valid` and `overflow` are low and filling starts in bank 0, which is also the first bank drained.
- R10: When both banks are full, the swap happens at the edge that takes the last word of the draining bank. A record presented in the following cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_valid | input | 1 | A sample record is presented this cycle |
| rec_data | input | 96 | Sample record; byte 0 in bits 7:0 |
| wr_valid | output | 1 | Output word is available |
| wr_ready | input | 1 | Memory writer takes the word this cycle |
| wr_data | output | 64 | Output word; earliest byte in bits 7:0 |
| wr_first | output | 1 | Marks word 0 of a block |
| overflow | output | 1 | Sticky flag: at least one record was dropped |

## Verification
The assertions check the properties that hold on every cycle. Output is held stable under backpressure. The overflow flag is sticky and only rises after a drop. `wr_valid` follows a completed block by one cycle. The block marker appears only on a valid word, and the last word of a block leaves only on a handshake. Only the bench scenarios can show the things that depend on the whole history of the block. These are that every byte lands in its proper lane and word, that blocks come out in capture order with no gap at a bank swap, that dropped records never reach the output, and that a record arriving just after the final drain handshake is kept.

// File: rtl/pp_buf_pkg.sv
package pp_buf_pkg;

  typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_t;

  // Byte offset of a record slot inside a bank.
  function automatic int rec_offset(int idx, int rec_bytes);
    return idx * rec_bytes;
  endfunction

  // Byte offset of an output word inside a bank.
  function automatic int word_offset(int idx, int word_bytes);
    return idx * word_bytes;
  endfunction

  function automatic bank_t other_bank(bank_t b);
    return bank_t'(~b);
  endfunction

endpackage

// File: rtl/pp_bank_store.sv
module pp_bank_store
  import pp_buf_pkg::*;
#(
  parameter int REC_BYTES  = 12,
  parameter int WORD_BYTES = 8,
  parameter int BLK_BYTES  = 192,
  parameter int RIDX_W     = 4,
  parameter int WIDX_W     = 5
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  bank_t                   wr_bank,
  input  logic [RIDX_W-1:0]       wr_idx,
  input  logic [REC_BYTES*8-1:0]  wr_rec,
  input  bank_t                   rd_bank,
  input  logic [WIDX_W-1:0]       rd_idx,
  output logic [WORD_BYTES*8-1:0] rd_word
);
  localparam int AW = $clog2(BLK_BYTES);

  logic [WORD_BYTES*8-1:0] bank_word [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [7:0] bytes_q [BLK_BYTES];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == bank_t'(b))) begin
        for (int j = 0; j < REC_BYTES; j++) begin
          bytes_q[AW'(rec_offset(int'(wr_idx), REC_BYTES) + j)] <= wr_rec[j*8 +: 8];
        end
      end
    end

    for (genvar i = 0; i < WORD_BYTES; i++) begin : g_lane
      assign bank_word[b][i*8 +: 8] =
        bytes_q[AW'(word_offset(int'(rd_idx), WORD_BYTES) + i)];
    end
  end

  assign rd_word = bank_word[rd_bank];

endmodule

// File: rtl/pp_fill_ctrl.sv
module pp_fill_ctrl
  import pp_buf_pkg::*;
#(
  parameter int RECS_PER_BLK = 16,
  parameter int RIDX_W       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_valid,
  input  logic              drain_clr,
  input  bank_t             drain_bank,
  output bank_t             fill_bank,
  output logic [RIDX_W-1:0] fill_idx,
  output logic              rec_take,
  output logic              rec_drop,
  output logic              blk_done,
  output logic [1:0]        full,
  output logic              overflow
);
  localparam logic [RIDX_W-1:0] LAST_REC = RIDX_W'(RECS_PER_BLK - 1);

  bank_t             fb_q;
  logic [RIDX_W-1:0] cnt_q;
  logic [1:0]        full_q;
  logic              ovf_q;
  logic              cur_full;
  logic              other_free;
  bank_t             ob;

  assign ob         = other_bank(fb_q);
  assign cur_full   = full_q[fb_q];
  // The other bank counts as free in the cycle its last word leaves.
  assign other_free = !full_q[ob] || (drain_clr && (drain_bank == ob));
  assign rec_take   = rec_valid && !cur_full;
  assign rec_drop   = rec_valid && cur_full;
  assign blk_done   = rec_take && (cnt_q == LAST_REC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fb_q   <= BANK_A;
      cnt_q  <= '0;
      full_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      for (int b = 0; b < 2; b++) begin
        if (blk_done && (fb_q == bank_t'(b))) begin
          full_q[b] <= 1'b1;
        end else if (drain_clr && (drain_bank == bank_t'(b))) begin
          full_q[b] <= 1'b0;
        end
      end
      if (rec_take) begin
        if (blk_done) begin
          cnt_q <= '0;
          if (other_free) fb_q <= ob;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (cur_full && other_free) begin
        fb_q <= ob;
      end
      if (rec_drop) ovf_q <= 1'b1;
    end
  end

  assign fill_bank = fb_q;
  assign fill_idx  = cnt_q;
  assign full      = full_q;
  assign overflow  = ovf_q;

endmodule

// File: rtl/pp_drain_ctrl.sv
module pp_drain_ctrl
  import pp_buf_pkg::*;
#(
  parameter int WORDS_PER_BLK = 24,
  parameter int WIDX_W        = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        full,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic              wr_first,
  output bank_t             rd_bank,
  output logic [WIDX_W-1:0] rd_idx,
  output logic              word_take,
  output logic              drain_last
);
  localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(WORDS_PER_BLK - 1);

  bank_t             db_q;
  logic [WIDX_W-1:0] widx_q;

  assign wr_valid   = full[db_q];
  assign wr_first   = wr_valid && (widx_q == '0);
  assign word_take  = wr_valid && wr_ready;
  assign drain_last = word_take && (widx_q == LAST_WORD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      db_q   <= BANK_A;
      widx_q <= '0;
    end else if (word_take) begin
      if (drain_last) begin
        widx_q <= '0;
        db_q   <= other_bank(db_q);
      end else begin
        widx_q <= widx_q + 1'b1;
      end
    end
  end

  assign rd_bank = db_q;
  assign rd_idx  = widx_q;

endmodule

// File: rtl/sample_pingpong_buf.sv
module sample_pingpong_buf
  import pp_buf_pkg::*;
#(
  parameter int REC_BYTES    = 12,
  parameter int RECS_PER_BLK = 16,
  parameter int WORD_BYTES   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rec_valid,
  input  logic [REC_BYTES*8-1:0]  rec_data,
  output logic                    wr_valid,
  input  logic                    wr_ready,
  output logic [WORD_BYTES*8-1:0] wr_data,
  output logic                    wr_first,
  output logic                    overflow
);
  localparam int BLK_BYTES     = REC_BYTES * RECS_PER_BLK;
  localparam int WORDS_PER_BLK = BLK_BYTES / WORD_BYTES;
  localparam int RIDX_W        = $clog2(RECS_PER_BLK);
  localparam int WIDX_W        = $clog2(WORDS_PER_BLK);

  bank_t             fill_bank;
  logic [RIDX_W-1:0] fill_idx;
  logic              rec_take;
  logic              rec_drop;
  logic              blk_done;
  logic [1:0]        full;
  bank_t             rd_bank;
  logic [WIDX_W-1:0] rd_idx;
  logic              word_take;
  logic              drain_last;

  pp_fill_ctrl #(
    .RECS_PER_BLK(RECS_PER_BLK),
    .RIDX_W      (RIDX_W)
  ) u_fill (
    .clk       (clk),
    .rst_n     (rst_n),
    .rec_valid (rec_valid),
    .drain_clr (drain_last),
    .drain_bank(rd_bank),
    .fill_bank (fill_bank),
    .fill_idx  (fill_idx),
    .rec_take  (rec_take),
    .rec_drop  (rec_drop),
    .blk_done  (blk_done),
    .full      (full),
    .overflow  (overflow)
  );

  pp_drain_ctrl #(
    .WORDS_PER_BLK(WORDS_PER_BLK),
    .WIDX_W       (WIDX_W)
  ) u_drain (
    .clk       (clk),
    .rst_n     (rst_n),
    .full      (full),
    .wr_ready  (wr_ready),
    .wr_valid  (wr_valid),
    .wr_first  (wr_first),
    .rd_bank   (rd_bank),
    .rd_idx    (rd_idx),
    .word_take (word_take),
    .drain_last(drain_last)
  );

  pp_bank_store #(
    .REC_BYTES (REC_BYTES),
    .WORD_BYTES(WORD_BYTES),
    .BLK_BYTES (BLK_BYTES),
    .RIDX_W    (RIDX_W),
    .WIDX_W    (WIDX_W)
  ) u_store (
    .clk    (clk),
    .wr_en  (rec_take),
    .wr_bank(fill_bank),
    .wr_idx (fill_idx),
    .wr_rec (rec_data),
    .rd_bank(rd_bank),
    .rd_idx (rd_idx),
    .rd_word(wr_data)
  );

endmodule

// File: rtl/pp_buf_checker.sv
module pp_buf_checker #(
  parameter int WORD_BITS = 64
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rec_drop,
  input logic                 blk_done,
  input logic                 wr_valid,
  input logic                 wr_ready,
  input logic [WORD_BITS-1:0] wr_data,
  input logic                 wr_first,
  input logic                 drain_last,
  input logic                 overflow
);

  a_r8_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_first)));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r7_set_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    rec_drop |=> overflow);

  a_r7_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(rec_drop));

  a_r4_valid_after_block: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> wr_valid);

  a_r3_first_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wr_first |-> wr_valid);

  a_r2_last_on_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    drain_last |-> (wr_valid && wr_ready && !wr_first));

endmodule

bind sample_pingpong_buf pp_buf_checker #(
  .WORD_BITS(WORD_BYTES * 8)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rec_drop  (rec_drop),
  .blk_done  (blk_done),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_data   (wr_data),
  .wr_first  (wr_first),
  .drain_last(drain_last),
  .overflow  (overflow)
);

// File: tb/sample_pingpong_buf_tb.sv
module sample_pingpong_buf_tb;
  localparam int RB = 12;
  localparam int NR = 16;
  localparam int WB = 8;
  localparam int NW = RB * NR / WB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rec_valid = 1'b0;
  logic [RB*8-1:0] rec_data = '0;
  logic          wr_valid;
  logic          wr_ready = 1'b1;
  logic [WB*8-1:0] wr_data;
  logic          wr_first;
  logic          overflow;

  int checks = 0;
  int failures = 0;
  int acc_id = 0;
  int wcnt = 0;
  int cyc = 0;
  int rdy_mode = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sample_pingpong_buf u_dut (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_data(rec_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .wr_first(wr_first), .overflow(overflow)
  );

  function automatic logic [7:0] pat_byte(int id, int j);
    return 8'((id * 29 + j * 11 + 5) & 255);
  endfunction

  function automatic logic [RB*8-1:0] pat_rec(int id);
    logic [RB*8-1:0] r;
    for (int j = 0; j < RB; j++) r[j*8 +: 8] = pat_byte(id, j);
    return r;
  endfunction

  // Expected word n of the output stream, from byte arithmetic alone.
  function automatic logic [WB*8-1:0] exp_word(int n);
    logic [WB*8-1:0] w;
    int blk = n / NW;
    int wi  = n % NW;
    for (int i = 0; i < WB; i++) begin
      int off = wi * WB + i;
      w[i*8 +: 8] = pat_byte(blk * NR + off / RB, off % RB);
    end
    return w;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    case (rdy_mode)
      0: wr_ready = 1'b1;
      1: wr_ready = (cyc % 3) != 0;
      default: wr_ready = 1'b0;
    endcase
  end

  // Output monitor: contents and marker (R2, R3), hold under stall (R8).
  logic          pv = 0, pr = 0, pf = 0;
  logic [63:0]   pd = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pv && !pr) begin
        chk(wr_valid && wr_data == pd && wr_first == pf, "R8 hold under stall",
            wr_data, pd);
      end
      if (wr_valid && wr_ready) begin
        chk(wr_data == exp_word(wcnt), "R2 word content", wr_data, exp_word(wcnt));
        chk(wr_first == ((wcnt % NW) == 0), "R3 block marker",
            64'(wr_first), 64'((wcnt % NW) == 0));
        wcnt++;
      end
      pv = wr_valid; pr = wr_ready; pd = wr_data; pf = wr_first;
    end
  end

  // Called and returning at posedge + 1.
  task automatic send_rec(int gap);
    rec_valid = 1'b1;
    rec_data  = pat_rec(acc_id);
    acc_id++;
    @(posedge clk); #1;
    rec_valid = 1'b0;
    repeat (gap) begin @(posedge clk); #1; end
  endtask

  task automatic send_junk();
    rec_valid = 1'b1;
    rec_data  = {RB{8'hEE}};
    @(posedge clk); #1;
    rec_valid = 1'b0;
  endtask

  task automatic wait_words(int target);
    while (wcnt < target) begin @(posedge clk); #1; end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", wcnt, acc_id / NR * NW);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    chk(!wr_valid, "R9 wr_valid low after reset", 64'(wr_valid), 0);
    chk(!overflow, "R9 overflow low after reset", 64'(overflow), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1/R4: first block, valid only after the 16th record
    for (int k = 0; k < NR - 1; k++) send_rec(1);
    chk(!wr_valid, "R4 no word before block complete", 64'(wr_valid), 0);
    rec_valid = 1'b1;
    rec_data  = pat_rec(acc_id);
    acc_id++;
    @(negedge clk);
    chk(!wr_valid, "R4 low while 16th record presented", 64'(wr_valid), 0);
    @(posedge clk); #1;
    rec_valid = 1'b0;
    @(negedge clk);
    chk(wr_valid && wr_first, "R4 valid with marker after 16th record",
        64'({wr_valid, wr_first}), 64'h3);
    @(posedge clk); #1;

    // R1/R2/R5: several blocks, full-rate drain, two-cycle record spacing
    for (int k = 0; k < 4 * NR; k++) send_rec(1);
    wait_words(acc_id / NR * NW);

    // R8: throttled drain, three-cycle record spacing
    rdy_mode = 1;
    for (int k = 0; k < 3 * NR; k++) send_rec(2);
    wait_words(acc_id / NR * NW);
    rdy_mode = 0;
    @(posedge clk); #1;
    chk(!overflow, "R7 no overflow without drops", 64'(overflow), 0);

    // R5/R6/R7: writer stalled, two blocks fill back to back, then drops
    rdy_mode = 2;
    @(posedge clk); #1;
    for (int k = 0; k < NR; k++) send_rec(0);
    for (int k = 0; k < NR; k++) send_rec(0);   // R5: no gap at swap
    chk(!overflow, "R5 second bank accepted without drop", 64'(overflow), 0);
    send_junk();
    @(negedge clk);
    chk(overflow, "R7 overflow after dropped record", 64'(overflow), 1);
    @(posedge clk); #1;
    send_junk();                                 // R6: also dropped
    repeat (5) @(posedge clk);
    #1;
    chk(overflow, "R7 overflow stays set", 64'(overflow), 1);
    chk(wr_valid && wr_first, "R8 first word still offered", 64'({wr_valid, wr_first}), 64'h3);

    // R10: record right after last handshake of the draining bank is kept
    rdy_mode = 0;
    wait_words((acc_id / NR - 1) * NW);
    for (int k = 0; k < NR; k++) send_rec(1);
    wait_words(acc_id / NR * NW);
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R6/R10: word count matches accepted records only
    chk(wcnt == acc_id / NR * NW, "R6 R10 total words", 64'(wcnt), 64'(acc_id / NR * NW));
    chk(!wr_valid, "R2 nothing left to drain", 64'(wr_valid), 0);
    chk(overflow, "R7 overflow held to end", 64'(overflow), 1);

    // R9: reset clears the sticky flag
    rst_n = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!overflow && !wr_valid, "R9 reset clears overflow", 64'({overflow, wr_valid}), 0);
    finish_run();
  end

endmodule